// File: doc/BRIEF.md
# Signed Integer Execution Unit

This block is the arithmetic and logic stage of a small register-machine core. Each operation starts with a one-cycle `start_i` strobe, which carries an opcode and two 32-bit signed operands. Logic upstream of the block has already chosen whether the second operand is a register value or a full 32-bit immediate. The block returns a registered result with a one-cycle `done_o` pulse. It raises `div_zero_o` together with `done_o` when a division or remainder is asked to divide by zero.

Most operations finish on the first clock edge after the start. Division and remainder run a restoring shift-subtract loop on operand magnitudes, one quotient bit per cycle. A sign fix-up then gives floored division and a remainder that takes the sign of the dividend. While that loop runs, the unit ignores any new start.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0 (add) returns opa+opb and opcode 1 (subtract) returns opa-opb. Both wrap modulo 2^32 and flag nothing.
- R2: Opcode 2 (multiply) returns the low 32 bits of opa*opb.
- R3: Opcode 3 (divide) returns the quotient of the signed operands rounded toward negative infinity. -2^31 divided by -1 wraps to 0x80000000.
- R4: Opcode 4 (remainder) returns the truncating remainder, which is zero or takes the sign of opa and has a magnitude below |opb|.
- R5: With opcode 3 or 4 and opb equal to zero, done_o rises on the first edge after the start with div_zero_o high and result_o zero. Every other completion has div_zero_o low.
- R6: Opcode 5 (set-less-than) returns exactly 1 when opa is below opb as signed numbers and 0 otherwise.
- R7: Opcodes 6, 7 and 8 return bitwise AND, OR and XOR. Opcode 9 returns ~opa, and opb has no effect on it.
- R8: Opcode 10 shifts left with zero fill. Opcode 11 shifts right with zero fill, and opcode 12 shifts right with sign fill. Each uses only opb[4:0] as the shift amount.
- R9: Every opcode except 3 and 4 raises done_o on the first clock edge after the start, and done_o stays high for one cycle only. The unused opcodes 13 to 15 return 0.
- R10: A divide or remainder with a nonzero divisor raises done_o exactly 32 clock edges after the edge that sampled the start, and done_o stays low until then.
- R11: A start that arrives while a division is in progress is ignored and does not change the division's result or timing.
- R12: After reset, result_o, done_o and div_zero_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First signed operand |
| opb_i | input | 32 | Second signed operand (register or immediate) |
| result_o | output | 32 | Registered result |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Divide or remainder by zero, valid with done_o |

## Verification
The assertions assume that start_i, op_i and the operands are known values whenever start_i is high. They also assume that reset is not applied in the middle of a division, because the latency counter in the checker restarts only on an accepted start. The bench drives every input on the falling edge and holds start_i for exactly one cycle. Its random operations mix full-range operands with small values and zero divisors, so that every division sign case and the divide-by-zero path are reached without any illegal stimulus.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_DIV = 4'd3,
        OP_REM = 4'd4,
        OP_SLT = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_NOT = 4'd9,
        OP_SLL = 4'd10,
        OP_SRL = 4'd11,
        OP_SRA = 4'd12
    } exu_op_e;

endpackage

// File: rtl/exu_shifter.sv
module exu_shifter #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic             left_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] res_o
);

    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] stg [SHW+1];
    logic             fill;

    // Left shifts reuse the right-shift network on a bit-reversed value.
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            rev_in[k] = val_i[WIDTH-1-k];
        end
    end

    assign fill   = arith_i & ~left_i & val_i[WIDTH-1];
    assign stg[0] = left_i ? rev_in : val_i;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        assign stg[i+1] = amt_i[i]
                        ? {{(2**i){fill}}, stg[i][WIDTH-1:(2**i)]}
                        : stg[i];
    end

    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            res_o[k] = left_i ? stg[SHW][WIDTH-1-k] : stg[SHW][k];
        end
    end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] prod;
    logic [WIDTH-1:0] shifted;
    logic             lt;
    logic             sh_left;
    logic             sh_arith;

    assign sum      = a_i + b_i;
    assign diff     = a_i - b_i;
    assign prod     = a_i * b_i;
    assign lt       = $signed(a_i) < $signed(b_i);
    assign sh_left  = (op_i == OP_SLL);
    assign sh_arith = (op_i == OP_SRA);

    exu_shifter #(.WIDTH(WIDTH)) u_shift (
        .val_i   (a_i),
        .amt_i   (b_i[SHW-1:0]),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .res_o   (shifted)
    );

    always_comb begin
        case (op_i)
            OP_ADD:                 res_o = sum;
            OP_SUB:                 res_o = diff;
            OP_MUL:                 res_o = prod;
            OP_SLT:                 res_o = {{(WIDTH-1){1'b0}}, lt};
            OP_AND:                 res_o = a_i & b_i;
            OP_OR:                  res_o = a_i | b_i;
            OP_XOR:                 res_o = a_i ^ b_i;
            OP_NOT:                 res_o = ~a_i;
            OP_SLL, OP_SRL, OP_SRA: res_o = shifted;
            default:                res_o = '0;
        endcase
    end

endmodule

// File: rtl/exu_div_step.sv
module exu_div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] quo_o
);

    logic [WIDTH:0] part;
    logic [WIDTH:0] trial;

    // One restoring step: bring in the next dividend bit, subtract if it fits.
    assign part  = {rem_i, quo_i[WIDTH-1]};
    assign trial = part - {1'b0, dvs_i};

    always_comb begin
        if (!trial[WIDTH]) begin
            rem_o = trial[WIDTH-1:0];
            quo_o = {quo_i[WIDTH-2:0], 1'b1};
        end else begin
            rem_o = part[WIDTH-1:0];
            quo_o = {quo_i[WIDTH-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/exu_div_fix.sv
module exu_div_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] qmag_i,
    input  logic [WIDTH-1:0] rmag_i,
    input  logic             neg_a_i,
    input  logic             neg_b_i,
    input  logic             want_rem_i,
    output logic [WIDTH-1:0] res_o
);

    logic             neg_q;
    logic [WIDTH-1:0] q_trunc;
    logic [WIDTH-1:0] r_trunc;
    logic [WIDTH-1:0] q_floor;

    assign neg_q   = neg_a_i ^ neg_b_i;
    assign q_trunc = neg_q   ? -qmag_i : qmag_i;
    assign r_trunc = neg_a_i ? -rmag_i : rmag_i;
    // Floor differs from truncation only for inexact negative quotients.
    assign q_floor = (neg_q && (rmag_i != '0)) ? q_trunc - 1'b1 : q_trunc;
    assign res_o   = want_rem_i ? r_trunc : q_floor;

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o,
    output logic             div_zero_o
);

    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] dvs;
        logic             neg_a;
        logic             neg_b;
        logic             want_rem;
        logic [WIDTH-1:0] res;
        logic             done;
        logic             dz;
    } exu_state_t;

    exu_state_t state_d, state_q;

    logic [WIDTH-1:0] alu_res;
    logic [WIDTH-1:0] step_rem;
    logic [WIDTH-1:0] step_quo;
    logic [WIDTH-1:0] fix_res;
    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic             is_div_op;
    logic             busy_w;

    assign mag_a     = opa_i[WIDTH-1] ? -opa_i : opa_i;
    assign mag_b     = opb_i[WIDTH-1] ? -opb_i : opb_i;
    assign is_div_op = (op_i == OP_DIV) || (op_i == OP_REM);
    assign busy_w    = state_q.busy;

    exu_alu #(.WIDTH(WIDTH)) u_alu (
        .op_i  (op_i),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (alu_res)
    );

    exu_div_step #(.WIDTH(WIDTH)) u_step (
        .rem_i (state_q.rem),
        .quo_i (state_q.quo),
        .dvs_i (state_q.dvs),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    exu_div_fix #(.WIDTH(WIDTH)) u_fix (
        .qmag_i     (step_quo),
        .rmag_i     (step_rem),
        .neg_a_i    (state_q.neg_a),
        .neg_b_i    (state_q.neg_b),
        .want_rem_i (state_q.want_rem),
        .res_o      (fix_res)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        state_d.dz   = 1'b0;
        if (state_q.busy) begin
            state_d.rem = step_rem;
            state_d.quo = step_quo;
            state_d.cnt = state_q.cnt + 1'b1;
            if (state_q.cnt == LAST_STEP) begin
                state_d.busy = 1'b0;
                state_d.res  = fix_res;
                state_d.done = 1'b1;
            end
        end else if (start_i) begin
            if (is_div_op) begin
                if (opb_i == '0) begin
                    state_d.res  = '0;
                    state_d.done = 1'b1;
                    state_d.dz   = 1'b1;
                end else begin
                    state_d.busy     = 1'b1;
                    state_d.cnt      = '0;
                    state_d.rem      = '0;
                    state_d.quo      = mag_a;
                    state_d.dvs      = mag_b;
                    state_d.neg_a    = opa_i[WIDTH-1];
                    state_d.neg_b    = opb_i[WIDTH-1];
                    state_d.want_rem = (op_i == OP_REM);
                end
            end else begin
                state_d.res  = alu_res;
                state_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o   = state_q.res;
    assign done_o     = state_q.done;
    assign div_zero_o = state_q.dz;

endmodule

// File: rtl/exu_chk.sv
module exu_chk
    import exu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [WIDTH-1:0] result_o,
    input logic             done_o,
    input logic             div_zero_o,
    input logic             busy
);

    localparam int WW = $clog2(WIDTH) + 2;

    logic          accept;
    logic          div_go;
    logic          pend_q;
    logic [WW-1:0] wait_q;

    assign accept = start_i && !busy;
    assign div_go = accept && (op_i == OP_DIV || op_i == OP_REM) && (opb_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            wait_q <= '0;
        end else if (div_go) begin
            pend_q <= 1'b1;
            wait_q <= '0;
        end else if (pend_q) begin
            wait_q <= wait_q + 1'b1;
            if (done_o) pend_q <= 1'b0;
        end
    end

    // R5
    dz_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> done_o);

    // R5
    dz_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (result_o == '0));

    // R9
    quick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i != OP_DIV && op_i != OP_REM) |=> (done_o && !div_zero_o));

    // R10
    div_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && done_o) |-> (wait_q == WW'(WIDTH)));

    // R10
    div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && wait_q < WW'(WIDTH)) |-> !done_o);

    // R11
    busy_no_dz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !div_zero_o);

    // R6
    slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == OP_SLT) |=> (result_o[WIDTH-1:1] == '0));

    // R7
    not_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == OP_NOT) |=> (result_o == ~$past(opa_i)));

endmodule

bind int_exec_unit exu_chk #(.WIDTH(WIDTH)) u_exu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (op_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .result_o   (result_o),
    .done_o     (done_o),
    .div_zero_o (div_zero_o),
    .busy       (busy_w)
);

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] result_o;
    logic        done_o;
    logic        div_zero_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    int_exec_unit i_int_exec_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .result_o   (result_o),
        .done_o     (done_o),
        .div_zero_o (div_zero_o)
    );

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] p;
        logic [31:0] sr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: begin p = 64'(a) * 64'(b); return p[31:0]; end
            4'd3, 4'd4: begin
                if (b == 32'd0) return 32'd0;
                q = sa / sb;
                r = sa % sb;
                if (op == 4'd4) return r[31:0];
                if (r != 0 && ((r < 0) != (sb < 0))) q = q - 1;
                return q[31:0];
            end
            4'd5: return (sa < sb) ? 32'd1 : 32'd0;
            4'd6: return a & b;
            4'd7: return a | b;
            4'd8: return a ^ b;
            4'd9: return ~a;
            4'd10: return a << b[4:0];
            4'd11: return a >> b[4:0];
            4'd12: begin sr = $signed(a) >>> b[4:0]; return sr; end
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R6";
            4'd6, 4'd7, 4'd8, 4'd9: return "R7";
            4'd10, 4'd11, 4'd12: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] res, output logic dz, output int lat);
        @(negedge clk);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        res = result_o;
        dz  = div_zero_o;
    endtask

    task automatic full_check(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] res;
        logic dz;
        int lat;
        logic is_div, zero_b;
        is_div = (op == 4'd3 || op == 4'd4);
        zero_b = is_div && (b == 32'd0);
        run_op(op, a, b, res, dz, lat);
        check(zero_b ? "R5" : req_of(op), "result", res, model(op, a, b));
        check("R5", "div_zero flag", 32'(dz), 32'(zero_b));
        check((is_div && !zero_b) ? "R10" : "R9", "latency", 32'(lat),
              (is_div && !zero_b) ? 32'd32 : 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] res, r1, r2;
        logic dz;
        int lat;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12", "reset result", result_o, 32'd0);
        check("R12", "reset done", 32'(done_o), 32'd0);
        check("R12", "reset div_zero", 32'(div_zero_o), 32'd0);
        rst_n = 1'b1;

        // R1 wrap
        full_check(4'd0, 32'h7fff_ffff, 32'd1);
        full_check(4'd1, 32'd0, 32'd1);
        // R2 low product bits
        full_check(4'd2, 32'h0001_0000, 32'h0001_0000);
        full_check(4'd2, 32'hffff_fffd, 32'd7);
        // R3 floor division
        full_check(4'd3, -32'sd7, 32'd2);
        full_check(4'd3, 32'd7, -32'sd2);
        full_check(4'd3, -32'sd7, -32'sd2);
        full_check(4'd3, 32'd6, -32'sd3);
        full_check(4'd3, 32'h8000_0000, 32'hffff_ffff);
        full_check(4'd3, 32'h8000_0000, 32'd1);
        // R4 remainder follows dividend
        full_check(4'd4, -32'sd7, 32'd2);
        full_check(4'd4, 32'd7, -32'sd2);
        full_check(4'd4, 32'h8000_0000, 32'hffff_ffff);
        // R5 zero divisor
        full_check(4'd3, 32'd55, 32'd0);
        full_check(4'd4, -32'sd9, 32'd0);
        // R6 signed compare
        full_check(4'd5, 32'hffff_ffff, 32'd0);
        full_check(4'd5, 32'd0, 32'hffff_ffff);
        full_check(4'd5, 32'd4, 32'd4);
        // R7 NOT ignores opb
        run_op(4'd9, 32'h1234_5678, 32'h0, r1, dz, lat);
        run_op(4'd9, 32'h1234_5678, 32'hffff_ffff, r2, dz, lat);
        check("R7", "not with other opb", r2, r1);
        check("R7", "not value", r1, 32'hedcb_a987);
        // R8 shift amount uses low 5 bits
        full_check(4'd10, 32'h0000_0003, 32'd33);
        full_check(4'd11, 32'h8000_0000, 32'd31);
        full_check(4'd12, 32'h8000_0000, 32'd31);
        full_check(4'd12, 32'hf000_0000, 32'd36);
        // R9 unused opcode and one-cycle pulse
        full_check(4'd14, 32'h5, 32'h6);
        @(negedge clk);
        check("R9", "done pulse width", 32'(done_o), 32'd0);

        // R11 start during division is ignored
        @(negedge clk);
        start_i = 1'b1; op_i = 4'd3; opa_i = -32'sd100; opb_i = 32'd7;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        repeat (4) begin @(posedge clk); @(negedge clk); lat++; end
        start_i = 1'b1; op_i = 4'd0; opa_i = 32'd1; opb_i = 32'd2;
        @(posedge clk);
        @(negedge clk);
        lat++;
        start_i = 1'b0;
        check("R11", "no early done", 32'(done_o), 32'd0);
        while (!done_o && lat < 100) begin @(posedge clk); @(negedge clk); lat++; end
        check("R11", "latency kept", 32'(lat), 32'd32);
        check("R11", "division result kept", result_o, 32'hffff_fff1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            logic [31:0] a, b;
            op = 4'($urandom_range(0, 15));
            a = $urandom();
            b = $urandom();
            if ($urandom_range(0, 3) == 0) a = 32'($signed(32'($urandom_range(0, 40))) - 20);
            if ($urandom_range(0, 3) == 0) b = 32'($signed(32'($urandom_range(0, 20))) - 10);
            if ($urandom_range(0, 15) == 0) b = 32'd0;
            full_check(op, a, b);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule